// File: doc/BRIEF.md
# Shadow Scan State Test Sequencer

This block keeps a shadow copy of a bank of processor state registers, one shadow bit per live bit, and runs short atomic tests on the logic that drives that state. Firmware writes a test pattern into the shadow copy one word at a time and can read any shadow word back. A single command exchanges the full shadow and live contents in one clock. A test command runs three cycles that cannot be interrupted: an exchange, one functional cycle of the surrounding logic, and a second exchange.

After a test, the shadow copy holds the response of the logic to the pattern, and the live state holds the value it had before the test began. Firmware reads the response back and compares it. Outside these exchanges the live state simply loads its functional next value every clock. The shadow copy changes only when firmware writes it or when an exchange occurs.

Top module: `scan_shadow_seq`

## Requirements
- R1: A write with `wr_en_i` high while `busy_o` is low stores `wr_data_i` into shadow word `wr_idx_i` at the next rising edge; shadow word i corresponds to bits [i*WORD_W +: WORD_W] of the live state.
- R2: `rd_data_o` shows shadow word `rd_idx_i` combinationally, with no clock in between.
- R3: A `cmd_swap_i` pulse while idle raises `busy_o` for one cycle; at the edge that ends that cycle the whole shadow copy and the whole live state exchange contents in both directions.
- R4: A `cmd_test_i` pulse while idle raises `busy_o` for exactly three cycles: the first edge exchanges shadow and live, the second loads the live state from `live_next_i`, and the third exchanges again. When both commands arrive together, the test runs.
- R5: After a test, the shadow copy holds the functional response to the pattern and `live_o` holds the value it showed during the first busy cycle.
- R6: `done_o` is high for exactly one cycle, the cycle after the final exchange of a swap or test, and `busy_o` is low in that cycle.
- R7: Commands arriving while `busy_o` is high start nothing, and writes while `busy_o` is high leave the shadow copy unchanged.
- R8: At every edge with no exchange, the live state loads `live_next_i`; the shadow copy changes only by R1 writes.
- R9: `rst_ni` low clears the shadow copy, `busy_o` and `done_o` at once and stops any running sequence; it leaves the live state loading `live_next_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset for shadow copy and sequencer |
| wr_en_i | input | 1 | Shadow word write strobe |
| wr_idx_i | input | IDX_W | Shadow word index for writes |
| wr_data_i | input | WORD_W | Shadow write data |
| rd_idx_i | input | IDX_W | Shadow word index for reads |
| rd_data_o | output | WORD_W | Shadow read data |
| cmd_swap_i | input | 1 | Request a single exchange |
| cmd_test_i | input | 1 | Request a three-cycle test |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| live_next_i | input | STATE_W | Functional next value of the live state |
| live_o | output | STATE_W | Live state |

## Verification
A command sampled at edge E0 shows `busy_o` from just after E0; a single exchange shows on `live_o` and the shadow reads right after E1, with `done_o` high only until E2. For a test the pattern appears on `live_o` after E1, its functional next value after E2, and the response with the restored live value and `done_o` after E3, all before E4. The bench drives and samples only on falling edges, one sample point per cycle of that timeline, and keeps its own model of the functional next-state function and of the live value saved in the first busy cycle. Reads are settled a fraction of a nanosecond after the read index changes, which checks that read data needs no clock.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_XCH1 = 3'd1,
    SQ_RUN  = 3'd2,
    SQ_XCH2 = 3'd3,
    SQ_SOLO = 3'd4
  } sq_state_e;

endpackage

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
  import scan_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic test_req_i,
  input  logic swap_req_i,
  output logic swap_o,
  output logic run_o,
  output logic busy_o,
  output logic done_o
);

  sq_state_e state_q, state_d;
  logic      done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (test_req_i)      state_d = SQ_XCH1;
        else if (swap_req_i) state_d = SQ_SOLO;
      end
      SQ_XCH1: state_d = SQ_RUN;
      SQ_RUN:  state_d = SQ_XCH2;
      SQ_XCH2: state_d = SQ_IDLE;
      SQ_SOLO: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == SQ_XCH2) || (state_q == SQ_SOLO);
    end
  end

  // exchange happens at the edge that ends an XCH1/XCH2/SOLO cycle
  assign swap_o = (state_q == SQ_XCH1) || (state_q == SQ_XCH2) || (state_q == SQ_SOLO);
  assign run_o  = (state_q == SQ_RUN);
  assign busy_o = (state_q != SQ_IDLE);
  assign done_o = done_q;

  a_r4_test_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_IDLE && test_req_i) |=> (state_q == SQ_XCH1));
  a_r4_xch1_to_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_XCH1) |=> (state_q == SQ_RUN));
  a_r4_run_to_xch2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_RUN) |=> (state_q == SQ_XCH2));
  a_r6_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_XCH2 || state_q == SQ_SOLO) |=> (done_o && !busy_o));
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_solo_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_SOLO) |=> (state_q == SQ_IDLE));

endmodule

// File: rtl/scan_shadow_bank.sv
module scan_shadow_bank #(
  parameter int WORD_W  = 16,
  parameter int NWORDS  = 4,
  parameter int IDX_W   = 2,
  parameter int STATE_W = WORD_W * NWORDS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               swap_i,
  input  logic [STATE_W-1:0] swap_data_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [WORD_W-1:0]  rd_data_o,
  output logic [STATE_W-1:0] state_o
);

  logic [WORD_W-1:0] word_q [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic hit;
    assign hit = wr_en_i && (int'(wr_idx_i) == g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      word_q[g] <= '0;
      else if (swap_i)  word_q[g] <= swap_data_i[g*WORD_W +: WORD_W];
      else if (hit)     word_q[g] <= wr_data_i;
    end

    assign state_o[g*WORD_W +: WORD_W] = word_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (int'(rd_idx_i) == i) rd_data_o = word_q[i];
    end
  end

endmodule

// File: rtl/scan_live_bank.sv
module scan_live_bank #(
  parameter int STATE_W = 64
) (
  input  logic               clk_i,
  input  logic               swap_i,
  input  logic [STATE_W-1:0] swap_data_i,
  input  logic [STATE_W-1:0] next_i,
  output logic [STATE_W-1:0] state_o
);

  logic [STATE_W-1:0] live_q;

  // no reset here: the functional logic supplies its own reset value via next_i
  always_ff @(posedge clk_i) begin
    if (swap_i) live_q <= swap_data_i;
    else        live_q <= next_i;
  end

  assign state_o = live_q;

endmodule

// File: rtl/scan_shadow_seq.sv
module scan_shadow_seq #(
  parameter int WORD_W = 16,
  parameter int NWORDS = 4,
  localparam int IDX_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int STATE_W = WORD_W * NWORDS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [WORD_W-1:0]  rd_data_o,
  input  logic               cmd_swap_i,
  input  logic               cmd_test_i,
  output logic               busy_o,
  output logic               done_o,
  input  logic [STATE_W-1:0] live_next_i,
  output logic [STATE_W-1:0] live_o
);

  logic               swap;
  logic               run;
  logic               busy;
  logic               wr_ok;
  logic [STATE_W-1:0] shadow;
  logic [STATE_W-1:0] live;

  scan_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .test_req_i (cmd_test_i),
    .swap_req_i (cmd_swap_i),
    .swap_o     (swap),
    .run_o      (run),
    .busy_o     (busy),
    .done_o     (done_o)
  );

  assign wr_ok = wr_en_i && !busy;

  scan_shadow_bank #(
    .WORD_W (WORD_W),
    .NWORDS (NWORDS),
    .IDX_W  (IDX_W)
  ) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .swap_i      (swap),
    .swap_data_i (live),
    .wr_en_i     (wr_ok),
    .wr_idx_i    (wr_idx_i),
    .wr_data_i   (wr_data_i),
    .rd_idx_i    (rd_idx_i),
    .rd_data_o   (rd_data_o),
    .state_o     (shadow)
  );

  scan_live_bank #(
    .STATE_W (STATE_W)
  ) u_live (
    .clk_i       (clk_i),
    .swap_i      (swap),
    .swap_data_i (shadow),
    .next_i      (live_next_i),
    .state_o     (live)
  );

  assign busy_o = busy;
  assign live_o = live;

  a_r3_exchange: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap |=> (shadow == $past(live) && live == $past(shadow)));
  a_r4_functional_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> (live == $past(live_next_i) && $stable(shadow)));
  a_r7_busy_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !swap && wr_en_i) |=> $stable(shadow));
  a_r8_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!swap && !wr_en_i) |=> $stable(shadow));
  a_r8_live_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap |=> (live == $past(live_next_i)));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r9_reset_clear: assert (shadow == '0 && !busy_o && !done_o);
    end
  end

endmodule

// File: tb/sim_scan_shadow_seq.sv
`timescale 1ns/100ps
module sim_scan_shadow_seq;

  localparam int WORD_W  = 16;
  localparam int NWORDS  = 4;
  localparam int IDX_W   = 2;
  localparam int STATE_W = WORD_W * NWORDS;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b1;
  logic               proc_rst = 1'b1;
  logic               wr_en = 1'b0;
  logic [IDX_W-1:0]   wr_idx = '0;
  logic [WORD_W-1:0]  wr_data = '0;
  logic [IDX_W-1:0]   rd_idx = '0;
  logic [WORD_W-1:0]  rd_data;
  logic               cmd_swap = 1'b0;
  logic               cmd_test = 1'b0;
  logic               busy, done;
  logic [STATE_W-1:0] live_next, live;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  function automatic logic [STATE_W-1:0] nf(input logic [STATE_W-1:0] s);
    logic [STATE_W-1:0] r;
    for (int i = 0; i < NWORDS; i++) begin
      logic [WORD_W-1:0] w;
      w = s[i*WORD_W +: WORD_W];
      r[i*WORD_W +: WORD_W] = {w[WORD_W-2:0], w[WORD_W-1]} ^ (16'h1d0f + 16'(i));
    end
    return r;
  endfunction

  assign live_next = proc_rst ? '0 : nf(live);

  scan_shadow_seq #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .cmd_swap_i(cmd_swap), .cmd_test_i(cmd_test),
    .busy_o(busy), .done_o(done),
    .live_next_i(live_next), .live_o(live)
  );

  task automatic chk(input bit ok, input string req, input logic [STATE_W-1:0] act,
                     input logic [STATE_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic get_shadow(output logic [STATE_W-1:0] v);
    for (int i = 0; i < NWORDS; i++) begin
      rd_idx = IDX_W'(i);
      #0.1;
      v[i*WORD_W +: WORD_W] = rd_data;
    end
  endtask

  task automatic load(input logic [STATE_W-1:0] p);
    for (int i = 0; i < NWORDS; i++) begin
      wr_en = 1'b1; wr_idx = IDX_W'(i); wr_data = p[i*WORD_W +: WORD_W];
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  function automatic logic [STATE_W-1:0] pat(input int p);
    logic [STATE_W-1:0] v;
    for (int i = 0; i < NWORDS; i++)
      v[i*WORD_W +: WORD_W] = 16'(p * 16'h3b1 + i * 16'h1111) ^ 16'(16'hffff * (p & 1));
    return v;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [STATE_W-1:0] sh, l1, prev, p;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    proc_rst = 1'b0;
    // R9 reset state
    get_shadow(sh);
    chk(sh == '0, "R9 shadow cleared", sh, '0);
    chk(!busy && !done, "R9 busy/done low", {busy, done}, '0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R8 free-running live state
    for (int k = 0; k < 4; k++) begin
      prev = live;
      @(negedge clk);
      chk(live == nf(prev), "R8 live follows next", live, nf(prev));
    end

    // R1 R2 writes and combinational reads over several patterns
    for (int q = 0; q < 4; q++) begin
      p = pat(q + 10);
      load(p);
      get_shadow(sh);
      chk(sh == p, "R1 R2 write/read", sh, p);
    end

    // R4 R5 R6 R7 tests over several patterns
    for (int q = 0; q < 6; q++) begin
      p = pat(q);
      load(p);
      cmd_test = 1'b1;
      if (q == 5) cmd_swap = 1'b1;  // both together: test wins
      @(negedge clk);                // after E0
      cmd_test = 1'b0;
      chk(busy, "R4 busy after cmd", busy, 1);
      l1 = live;
      cmd_swap = 1'b1;               // R7 ignored while busy
      cmd_test = (q == 2);
      @(negedge clk);                // after E1
      cmd_test = 1'b0;
      chk(live == p, "R4 pattern on live", live, p);
      chk(busy && !done, "R4 busy second cycle", {busy, done}, 2'b10);
      get_shadow(sh);
      chk(sh == l1, "R3 live saved in shadow", sh, l1);
      wr_en = 1'b1; wr_idx = '0; wr_data = 16'hdead;
      @(negedge clk);                // after E2
      wr_en = 1'b0;
      chk(live == nf(p), "R4 one functional cycle", live, nf(p));
      chk(busy, "R4 busy third cycle", busy, 1);
      get_shadow(sh);
      chk(sh == l1, "R7 write during busy ignored", sh, l1);
      @(negedge clk);                // after E3
      cmd_swap = 1'b0;
      chk(done && !busy, "R6 done after last swap", {busy, done}, 2'b01);
      chk(live == l1, "R5 live restored", live, l1);
      get_shadow(sh);
      chk(sh == nf(p), "R5 response in shadow", sh, nf(p));
      @(negedge clk);                // after E4
      chk(!done && !busy, "R6 done one cycle", {busy, done}, 2'b00);
      chk(live == nf(l1), "R7 no extra sequence", live, nf(l1));
    end

    // R3 single exchange
    for (int q = 0; q < 3; q++) begin
      p = pat(q + 20);
      load(p);
      cmd_swap = 1'b1;
      @(negedge clk);                // after E0
      cmd_swap = 1'b0;
      chk(busy, "R3 busy one cycle", busy, 1);
      l1 = live;
      @(negedge clk);                // after E1
      chk(live == p, "R3 shadow to live", live, p);
      get_shadow(sh);
      chk(sh == l1, "R3 live to shadow", sh, l1);
      chk(done && !busy, "R6 done after swap", {busy, done}, 2'b01);
      @(negedge clk);
      chk(!done, "R6 done drops", done, 0);
      chk(live == nf(p), "R8 live resumes", live, nf(p));
    end

    // R9 reset in the middle of a test
    load(pat(30));
    cmd_test = 1'b1;
    @(negedge clk);
    cmd_test = 1'b0;
    @(negedge clk);                  // after E1, state RUN
    rst_ni = 1'b0;
    prev = live;
    #0.5;
    chk(!busy, "R9 reset stops sequence", busy, 0);
    get_shadow(sh);
    chk(sh == '0, "R9 reset clears shadow", sh, '0);
    @(negedge clk);
    chk(live == nf(prev), "R9 live untouched by reset", live, nf(prev));
    rst_ni = 1'b1;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule